// File: doc/BRIEF.md
# Programmable High/Low Count Clock Divider

This block turns one fast input clock into several slower clocks. Each output channel holds two counts: the number of input cycles the output stays high and the number it stays low. The output period is their sum, and the duty cycle is the high count over that sum. A channel can also move its falling edge half an input cycle later, which gives a near-even duty cycle on an odd total. It can also be switched to pass the input clock straight through, which is division by one.

Settings arrive through a plain write port: a strobe, an address and a 32-bit data word. A written setting first lands in a per-channel holding register. The running counter only picks it up once its current output period is complete, so a write never cuts a period short or stretches it. There is no back-pressure on the write port: every strobed write is taken in the cycle it is presented. One synchronous reset clears every channel, so all outputs leave reset edge-aligned. Each output is built from registered state. The only exception is pass-through mode, where the input clock is routed to the output.

Top module: `clkdiv_hilo`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, every output is low afterwards. Every channel returns to high count 1, low count 1, half-cycle adjustment off and pass-through off, which gives divide-by-2 with an 8 ns period at a 4 ns input clock.
- R2: Outside pass-through, each output period consists of a high phase of exactly H input cycles followed by a low phase of exactly L input cycles, where H and L are the applied counts.
- R3: A write with address bit 0 = 0 is a count word. Bits [7:0] hold H, bits [30:23] hold L, and bit 31 enables the half-cycle adjustment.
- R4: A written H or L of 0 is applied as 1.
- R5: With the adjustment bit set, the high phase lasts H + 0.5 input cycles and the low phase lasts L - 0.5 cycles. With it clear, both phases are whole cycles.
- R6: A write with address bit 0 = 1 is a pass-through word, and bit 8 of that word enables pass-through. While pass-through is applied, the output equals the input clock. When pass-through is left, a new period starts with its high phase.
- R7: A written setting is applied only at the end of the low phase of the period in progress. That period completes with its old high and low lengths.
- R8: Address bits [ADDR_W-1:1] select the channel. A write to a channel index of NUM_CH or above changes no channel.
- R9: After reset is released, every channel raises its output on the first rising clock edge, and channels holding equal settings toggle at the same instants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high, common to all channels |
| wr_en_i | input | 1 | Write strobe, one write per cycle in which it is high |
| wr_addr_i | input | ADDR_W | Channel index in the upper bits, word select in bit 0 |
| wr_data_i | input | 32 | Count word or pass-through word |
| div_clk_o | output | NUM_CH | Divided clock, one bit per channel |

## Verification
The divider is driven with several count pairs: symmetric, strongly asymmetric, zero counts, an odd total with and without the half-cycle adjustment, and pass-through. Each setting is judged by measuring the length of the output's high and low phases in time. This separates an off-by-one in either phase, swapped fields, a wrong adjustment direction and a missing clamp of zero counts. A write issued in the middle of a high phase shows whether the period in progress keeps its old lengths before the new ones appear. Writes to one channel and to an unused index, checked against the other channels, show that the address decode selects a single channel. Sampling all outputs right after reset release shows that the channels start edge-aligned.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CNT_W   = 8;
  localparam int DATA_W  = 32;
  localparam int HI_LSB  = 0;
  localparam int LO_LSB  = 23;
  localparam int ODD_BIT = 31;
  localparam int BYP_BIT = 8;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
    logic             odd;
    logic             byp;
  } div_cfg_t;

  localparam div_cfg_t CFG_RESET = '{hi: CNT_W'(1), lo: CNT_W'(1), odd: 1'b0, byp: 1'b0};

  function automatic logic [CNT_W-1:0] min_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction
endpackage

// File: rtl/clkdiv_shadow.sv
module clkdiv_shadow
  import clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_cnt_i,
  input  logic              wr_byp_i,
  input  logic [DATA_W-1:0] data_i,
  output div_cfg_t          shadow_o
);
  div_cfg_t held_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      held_q <= CFG_RESET;
    end else begin
      if (wr_cnt_i) begin
        held_q.hi  <= min_one(data_i[HI_LSB +: CNT_W]);
        held_q.lo  <= min_one(data_i[LO_LSB +: CNT_W]);
        held_q.odd <= data_i[ODD_BIT];
      end
      if (wr_byp_i) begin
        held_q.byp <= data_i[BYP_BIT];
      end
    end
  end

  assign shadow_o = held_q;

  // R4: a held count is never zero
  a_r4_nonzero_counts: assert property (@(posedge clk_i) disable iff (rst_i)
    (held_q.hi != '0) && (held_q.lo != '0));
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  div_cfg_t shadow_i,
  output logic     phase_o,
  output logic     odd_o,
  output logic     byp_o
);
  div_cfg_t         act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;
  logic             end_hi;
  logic             boundary;

  assign end_hi   = ph_q && (cnt_q == act_q.hi - CNT_W'(1));
  assign boundary = act_q.byp || (!ph_q && (cnt_q == act_q.lo - CNT_W'(1)));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      act_q <= CFG_RESET;
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else if (boundary) begin
      act_q <= shadow_i;
      ph_q  <= 1'b1;
      cnt_q <= '0;
    end else if (end_hi) begin
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign phase_o = ph_q;
  assign odd_o   = act_q.odd;
  assign byp_o   = act_q.byp;

  // R2: the counter stays inside the length of the current phase
  a_r2_cnt_in_phase: assert property (@(posedge clk_i) disable iff (rst_i)
    !act_q.byp |-> (ph_q ? (cnt_q < act_q.hi) : (cnt_q < act_q.lo)));

  // R7: applied settings change only at a period boundary
  a_r7_hold_until_boundary: assert property (@(posedge clk_i) disable iff (rst_i)
    !boundary |=> $stable(act_q));

  // R9: a new high phase starts only after a boundary
  a_r9_rise_at_boundary: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ph_q) |-> $past(boundary));

  // R6: in pass-through the phase is parked high, ready for the next period
  a_r6_bypass_parks_high: assert property (@(posedge clk_i) disable iff (rst_i)
    act_q.byp |=> ph_q);
endmodule

// File: rtl/clkdiv_shaper.sv
module clkdiv_shaper (
  input  logic clk_i,
  input  logic rst_i,
  input  logic phase_i,
  input  logic odd_i,
  input  logic byp_i,
  output logic clk_o
);
  logic ph_neg_q;

  always_ff @(negedge clk_i) begin
    if (rst_i) ph_neg_q <= 1'b0;
    else       ph_neg_q <= phase_i;
  end

  assign clk_o = byp_i ? clk_i : (phase_i | (odd_i & ph_neg_q));
endmodule

// File: rtl/clkdiv_hilo.sv
module clkdiv_hilo
  import clkdiv_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 1 + ((NUM_CH > 1) ? $clog2(NUM_CH) : 1)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NUM_CH-1:0] div_clk_o
);
  localparam int CH_W = ADDR_W - 1;

  logic [CH_W-1:0] ch_sel;
  assign ch_sel = wr_addr_i[ADDR_W-1:1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic     hit;
    logic     wr_cnt;
    logic     wr_byp;
    div_cfg_t shadow;
    logic     phase;
    logic     odd;
    logic     byp;

    assign hit    = wr_en_i && (ch_sel == CH_W'(c));
    assign wr_cnt = hit && !wr_addr_i[0];
    assign wr_byp = hit &&  wr_addr_i[0];

    clkdiv_shadow u_shadow (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .wr_cnt_i (wr_cnt),
      .wr_byp_i (wr_byp),
      .data_i   (wr_data_i),
      .shadow_o (shadow)
    );

    clkdiv_counter u_counter (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .shadow_i (shadow),
      .phase_o  (phase),
      .odd_o    (odd),
      .byp_o    (byp)
    );

    clkdiv_shaper u_shaper (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .phase_i (phase),
      .odd_i   (odd),
      .byp_i   (byp),
      .clk_o   (div_clk_o[c])
    );
  end
endmodule

// File: tb/clkdiv_hilo_tb_top.sv
`timescale 1ns/1ps
module clkdiv_hilo_tb_top;
  localparam int NCH = 3;
  localparam int AW  = 3;
  localparam real TCK = 4.0;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [31:0]    wr_data = '0;
  logic [NCH-1:0] div_clk;

  int n_checks = 0;
  int n_fail   = 0;
  int mch      = 0;
  logic mon;

  always #2 clk = ~clk;
  always_comb mon = div_clk[mch];

  clkdiv_hilo #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .div_clk_o (div_clk)
  );

  function automatic logic [31:0] cnt_word(input int hi, input int lo, input bit odd);
    return {odd, 8'(lo), 15'b0, 8'(hi)};
  endfunction

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_time(input string tag, input real act, input real exp);
    n_checks++;
    if ((act - exp > 0.01) || (exp - act > 0.01)) begin
      n_fail++;
      $display("FAIL %s: actual %0.2f ns expected %0.2f ns", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input bit sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {2'(ch), sel}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic measure(input int ch, input real exp_hi, input real exp_lo, input string tag);
    real t0, t1, t2;
    mch = ch;
    #0.1;
    @(posedge mon); t0 = $realtime;
    @(negedge mon); t1 = $realtime;
    @(posedge mon); t2 = $realtime;
    chk_time({tag, " high"}, t1 - t0, exp_hi);
    chk_time({tag, " low"},  t2 - t1, exp_lo);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) chk_bit("R1 output low in reset", div_clk[c], 1'b0);
    rst = 1'b0;
    @(posedge clk); #1;
    for (int c = 0; c < NCH; c++) chk_bit("R9 first rise after release", div_clk[c], 1'b1);
    for (int k = 0; k < 6; k++) begin
      #2;
      chk_bit("R9 channels aligned ch1", div_clk[1], div_clk[0]);
      chk_bit("R9 channels aligned ch2", div_clk[2], div_clk[0]);
    end
    measure(0, 4.0, 4.0, "R1 default divide-by-2");
  endtask

  task automatic t_ratio();
    wr(0, 1'b0, cnt_word(3, 5, 1'b0)); settle();
    measure(0, 3*TCK, 5*TCK, "R2 R3 hi3 lo5");
    wr(0, 1'b0, cnt_word(1, 6, 1'b0)); settle();
    measure(0, 1*TCK, 6*TCK, "R2 R3 hi1 lo6");
    wr(0, 1'b0, cnt_word(7, 2, 1'b0)); settle();
    measure(0, 7*TCK, 2*TCK, "R2 R3 hi7 lo2");
  endtask

  task automatic t_zero();
    wr(0, 1'b0, cnt_word(0, 0, 1'b0)); settle();
    measure(0, TCK, TCK, "R4 both zero");
    wr(0, 1'b0, cnt_word(0, 2, 1'b0)); settle();
    measure(0, TCK, 2*TCK, "R4 high zero");
  endtask

  task automatic t_odd();
    wr(0, 1'b0, cnt_word(2, 3, 1'b1)); settle();
    measure(0, 2.5*TCK, 2.5*TCK, "R5 odd on hi2 lo3");
    wr(0, 1'b0, cnt_word(2, 3, 1'b0)); settle();
    measure(0, 2*TCK, 3*TCK, "R5 odd off hi2 lo3");
  endtask

  task automatic t_bypass();
    wr(0, 1'b1, 32'h0000_0100); settle();
    measure(0, TCK/2, TCK/2, "R6 pass-through");
    wr(0, 1'b0, cnt_word(2, 2, 1'b0));
    wr(0, 1'b1, 32'h0000_0000); settle();
    measure(0, 2*TCK, 2*TCK, "R6 leave pass-through");
  endtask

  task automatic t_shadow();
    real t0, t1, t2, t3, t4;
    wr(0, 1'b0, cnt_word(3, 3, 1'b0)); settle();
    mch = 0; #0.1;
    @(posedge mon); t0 = $realtime;
    wr(0, 1'b0, cnt_word(5, 2, 1'b0));
    @(negedge mon); t1 = $realtime;
    @(posedge mon); t2 = $realtime;
    @(negedge mon); t3 = $realtime;
    @(posedge mon); t4 = $realtime;
    chk_time("R7 current high kept", t1 - t0, 3*TCK);
    chk_time("R7 current low kept",  t2 - t1, 3*TCK);
    chk_time("R7 next high new",     t3 - t2, 5*TCK);
    chk_time("R7 next low new",      t4 - t3, 2*TCK);
  endtask

  task automatic t_channels();
    wr(0, 1'b0, cnt_word(2, 2, 1'b0));
    wr(1, 1'b0, cnt_word(1, 3, 1'b0));
    wr(3, 1'b0, cnt_word(7, 7, 1'b0));
    wr(3, 1'b1, 32'h0000_0100);
    settle();
    measure(0, 2*TCK, 2*TCK, "R8 ch0 own setting");
    measure(1, 1*TCK, 3*TCK, "R8 ch1 own setting");
    measure(2, 1*TCK, 1*TCK, "R8 ch2 untouched by index 3");
  endtask

  initial begin
    t_reset();
    t_ratio();
    t_zero();
    t_odd();
    t_bypass();
    t_shadow();
    t_channels();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule